// File: doc/BRIEF.md
# Single-Slope PWM Timer

The block is an 8-bit up-counter that runs single-slope. It counts from 0 to 255, wraps to 0, and drives one waveform output. A selectable prescaler turns the input clock into count ticks. A compare unit compares the count against an active threshold and shapes the output in one of three ways: non-inverted pulse width, inverted pulse width, or toggle on match. The PWM frequency is the input clock divided by 256 times the chosen division factor.

Software writes a new threshold into a holding register. That value reaches the comparator only when the count wraps, so a period is never cut short or stretched by a write part-way through. Two sticky flags report the wrap and the compare match, and each is cleared by writing one to it. The wrap flag can raise an interrupt request.

The output shaper is a three-state machine:
- `WV_OFF`: pin not driven, output low.
- `WV_LOW`: driven low.
- `WV_HIGH`: driven high.

Its transitions are:
- any state → `WV_OFF` when the mode is 0;
- `WV_OFF` → `WV_LOW` when a non-zero mode is selected;
- `WV_LOW` → `WV_HIGH` on wrap (mode 2), on match without wrap (mode 3), or on match (mode 1);
- `WV_HIGH` → `WV_LOW` on match without wrap (mode 2), on wrap (mode 3), or on match (mode 1).

Top module: `pwm_fast_timer`

## Requirements
- R1: A synchronous active-high reset clears the count, the prescaler, both thresholds and both flags. While reset is held, `wave_out`, `wave_oe`, `ovf_flag`, `cmp_flag` and `irq` are all 0.
- R2: Each tick advances the count by one, from 255 back to 0, so a period is 256 ticks. The tick that moves the count from 255 to 0 sets `ovf_flag` at that clock edge.
- R3: In `out_mode` 2, the output goes high on the wrap tick and goes low on a match tick (a tick where the count equals the active threshold). When both happen on the same tick, the output stays high.
- R4: In `out_mode` 3, the output goes low on the wrap tick and goes high on a match tick. When both happen on the same tick, the output stays low.
- R5: In `out_mode` 1, the output inverts on every match tick. With a threshold of 0 it is a 50% duty square wave with a period of 512 ticks.
- R6: In `out_mode` 0, the output is low and `wave_oe` is 0 from the next clock edge. When a non-zero mode is selected, `wave_oe` becomes 1 one edge later and the output starts low.
- R7: `clk_sel` 0 stops the ticks. Codes 1 to 7 give one tick per 1, 8, 32, 64, 128, 256 or 1024 clocks respectively.
- R8: A change of `clk_sel` restarts the prescaler's internal count. No tick occurs on the cycle of the change, and the next tick comes a full divided period later.
- R9: In mode 2, a threshold of 0 gives one high tick in every 256 ticks, and a threshold of 255 keeps the output high. Mode 3 gives the complement of both.
- R10: A `cmp_wr` pulse stores `cmp_wdata` in a holding register. The holding register is copied to the active threshold only on the wrap tick, so the period in progress keeps its old threshold.
- R11: A match tick sets `cmp_flag`. Both flags stay set until `ovf_clr` or `cmp_clr` is pulsed high. A set and a clear on the same edge leave the flag set.
- R12: `irq` is high exactly when `ovf_flag` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Prescaler select (0 = stopped) |
| out_mode | input | 2 | Output mode: 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| cmp_wr | input | 1 | Write strobe for the threshold holding register |
| cmp_wdata | input | 8 | Threshold value to write |
| irq_en | input | 1 | Enables the interrupt request from the wrap flag |
| ovf_clr | input | 1 | Write-one-to-clear for the wrap flag |
| cmp_clr | input | 1 | Write-one-to-clear for the match flag |
| wave_out | output | 1 | Waveform output |
| wave_oe | output | 1 | High while the waveform generator drives the pin |
| ovf_flag | output | 1 | Sticky wrap flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that reset is applied from time zero and that every input is a clean synchronous level, with each of the four mode codes legal at any time. The stimulus keeps within this by driving inputs only between clock edges. It holds the prescaler select mostly at fast settings and changes it rarely, so that ticks, wraps and matches keep occurring instead of the divider being restarted forever. It biases threshold writes toward 0 and 255 so that the extreme waveforms and the simultaneous wrap-and-match case appear often.

// File: rtl/pwm_fast_pkg.sv
package pwm_fast_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        WV_OFF  = 2'd0,
        WV_LOW  = 2'd1,
        WV_HIGH = 2'd2
    } wave_state_t;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } out_mode_t;

    // log2 of the division factor for each select code
    function automatic int unsigned div_shift(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            3'd7:    return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_fast_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;
    logic             run;
    logic             changed;

    always_comb begin
        lim     = DIV_W'((32'd1 << div_shift(sel)) - 32'd1);
        run     = (sel != '0);
        changed = (sel != sel_q);
        tick    = run && !changed && (div_q == lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            div_q <= '0;
        end else begin
            sel_q <= sel;
            if (!run || changed || tick) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_slope_counter.sv
module pwm_slope_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp_act,
    output logic             wrap,
    output logic             match
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] act_q;

    always_comb begin
        cnt     = cnt_q;
        cmp_act = act_q;
        wrap    = tick && (cnt_q == TOP);
        match   = tick && (cnt_q == act_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (wrap) begin
                act_q <= hold_q;
            end
            if (wr_en) begin
                hold_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
    import pwm_fast_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       wrap,
    input  logic       match,
    output logic       wave,
    output logic       wave_oe
);

    wave_state_t st_q;
    wave_state_t st_d;
    out_mode_t   om;

    assign om = out_mode_t'(mode);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= WV_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (om == OM_OFF) begin
            st_d = WV_OFF;
        end else begin
            unique case (st_q)
                WV_OFF: st_d = WV_LOW;
                WV_LOW: begin
                    case (om)
                        OM_TOGGLE: if (match)          st_d = WV_HIGH;
                        OM_NONINV: if (wrap)           st_d = WV_HIGH;
                        OM_INV:    if (match && !wrap) st_d = WV_HIGH;
                        default:   st_d = WV_LOW;
                    endcase
                end
                WV_HIGH: begin
                    case (om)
                        OM_TOGGLE: if (match)          st_d = WV_LOW;
                        OM_NONINV: if (match && !wrap) st_d = WV_LOW;
                        OM_INV:    if (wrap)           st_d = WV_LOW;
                        default:   st_d = WV_HIGH;
                    endcase
                end
                default: st_d = WV_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        wave    = (st_q == WV_HIGH);
        wave_oe = (st_q != WV_OFF);
    end

endmodule

// File: rtl/pwm_fast_timer.sv
module pwm_fast_timer #(
    parameter int CNT_W = 8,
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       clk_sel,
    input  logic [1:0]       out_mode,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             irq_en,
    input  logic             ovf_clr,
    input  logic             cmp_clr,
    output logic             wave_out,
    output logic             wave_oe,
    output logic             ovf_flag,
    output logic             cmp_flag,
    output logic             irq
);

    logic             tick;
    logic             wrap;
    logic             match;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp_act;
    logic             ovf_q;
    logic             cmf_q;

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (clk_sel),
        .tick (tick)
    );

    pwm_slope_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (cmp_wr),
        .wr_data (cmp_wdata),
        .cnt     (cnt),
        .cmp_act (cmp_act),
        .wrap    (wrap),
        .match   (match)
    );

    pwm_wavegen u_wave (
        .clk     (clk),
        .rst     (rst),
        .mode    (out_mode),
        .wrap    (wrap),
        .match   (match),
        .wave    (wave_out),
        .wave_oe (wave_oe)
    );

    // sticky flags, set has priority over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            cmf_q <= 1'b0;
        end else begin
            if (wrap)         ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;
            if (match)        cmf_q <= 1'b1;
            else if (cmp_clr) cmf_q <= 1'b0;
        end
    end

    assign ovf_flag = ovf_q;
    assign cmp_flag = cmf_q;
    assign irq      = ovf_q & irq_en;

endmodule

// File: rtl/pwm_fast_timer_chk.sv
module pwm_fast_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       clk_sel,
    input logic [1:0]       out_mode,
    input logic             irq_en,
    input logic             ovf_clr,
    input logic             wave_out,
    input logic             wave_oe,
    input logic             ovf_flag,
    input logic             cmp_flag,
    input logic             irq,
    input logic             tick,
    input logic             wrap,
    input logic             match,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_act
);

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == $past(cnt) + 1'b1));

    p_wrap_flag_r2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_flag);

    p_pin_off_r6: assert property (@(posedge clk) disable iff (rst)
        (out_mode == 2'd0) |=> (!wave_oe && !wave_out));

    p_stopped_r7: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 3'd0) |-> !tick);

    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    p_act_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cmp_act));

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_match_flag_r11: assert property (@(posedge clk) disable iff (rst)
        match |=> cmp_flag);

    p_irq_mask_r12: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    p_irq_src_r12: assert property (@(posedge clk) disable iff (rst)
        irq |-> ovf_flag);

endmodule

bind pwm_fast_timer pwm_fast_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_sel  (clk_sel),
    .out_mode (out_mode),
    .irq_en   (irq_en),
    .ovf_clr  (ovf_clr),
    .wave_out (wave_out),
    .wave_oe  (wave_oe),
    .ovf_flag (ovf_flag),
    .cmp_flag (cmp_flag),
    .irq      (irq),
    .tick     (tick),
    .wrap     (wrap),
    .match    (match),
    .cnt      (cnt),
    .cmp_act  (cmp_act)
);

// File: tb/sim_pwm_fast_timer.sv
module sim_pwm_fast_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] clk_sel = 3'd0;
    logic [1:0] out_mode = 2'd0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic       irq_en = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       cmp_clr = 1'b0;
    logic       wave_out, wave_oe, ovf_flag, cmp_flag, irq;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    pwm_fast_timer u0 (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .out_mode(out_mode),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .irq_en(irq_en),
        .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .wave_out(wave_out),
        .wave_oe(wave_oe), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model built from the requirements ----------------
    int m_cnt, m_hold, m_act, m_div, m_st, m_selq;  // m_st: 0 off, 1 low, 2 high
    bit m_ovf, m_cmf;

    function automatic int div_of(input int s);
        case (s)
            1: return 1;
            2: return 8;
            3: return 32;
            4: return 64;
            5: return 128;
            6: return 256;
            7: return 1024;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit chg, tk, wr, mt;
        int nst;
        if (rst) begin
            m_cnt = 0; m_hold = 0; m_act = 0; m_div = 0; m_st = 0; m_selq = 0;
            m_ovf = 0; m_cmf = 0;
        end else begin
            chg = (int'(clk_sel) != m_selq);                       // R8
            tk  = (clk_sel != 0) && !chg && (m_div == div_of(int'(clk_sel)) - 1); // R7
            wr  = tk && (m_cnt == 255);
            mt  = tk && (m_cnt == m_act);
            nst = m_st;
            if (out_mode == 2'd0) nst = 0;
            else if (m_st == 0) nst = 1;
            else begin
                case (out_mode)
                    2'd1: if (mt) nst = (m_st == 2) ? 1 : 2;
                    2'd2: if (wr) nst = 2; else if (mt) nst = 1;
                    2'd3: if (wr) nst = 1; else if (mt) nst = 2;
                    default: nst = m_st;
                endcase
            end
            m_st   = nst;
            m_div  = (chg || tk || clk_sel == 0) ? 0 : m_div + 1;
            m_selq = int'(clk_sel);
            if (wr) m_act = m_hold;
            if (cmp_wr) m_hold = int'(cmp_wdata);
            if (tk) m_cnt = (m_cnt + 1) % 256;
            m_ovf = wr ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
            m_cmf = mt ? 1'b1 : (cmp_clr ? 1'b0 : m_cmf);
        end
    end

    // ---------------- checking ----------------
    task automatic chk1(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // wait to the next falling edge and compare all outputs with the model
    task automatic step();
        string wtag;
        @(negedge clk);
        case (out_mode)
            2'd0: wtag = "R6";
            2'd1: wtag = "R5";
            2'd2: wtag = "R3";
            default: wtag = "R4";
        endcase
        chk1(wtag, "wave_out", int'(wave_out), (m_st == 2) ? 1 : 0);
        chk1("R6", "wave_oe", int'(wave_oe), (m_st != 0) ? 1 : 0);
        chk1("R2/R7/R8", "ovf_flag", int'(ovf_flag), int'(m_ovf));
        chk1("R11", "cmp_flag", int'(cmp_flag), int'(m_cmf));
        chk1("R12", "irq", int'(irq), int'(m_ovf && irq_en));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_cmp(input int v);
        cmp_wr = 1'b1; cmp_wdata = 8'(v);
        step();
        cmp_wr = 1'b0;
    endtask

    // high samples over a window of n cycles
    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            step();
            h += int'(wave_out);
        end
    endtask

    task automatic wait_ovf(input int limit);
        for (int i = 0; i < limit && !ovf_flag; i++) step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT && !done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WDOG_LIMIT);
            summary();
        end
    end

    initial begin
        int h;
        int gap;
        void'($urandom(32'd20240611));

        // R1: reset state
        run(3);
        chk1("R1", "wave_out in reset", int'(wave_out), 0);
        chk1("R1", "wave_oe in reset", int'(wave_oe), 0);
        chk1("R1", "flags in reset", int'(ovf_flag) + int'(cmp_flag) + int'(irq), 0);
        rst = 1'b0;

        // R3: non-inverted, threshold 100 -> 101 high ticks per period
        clk_sel = 3'd1; out_mode = 2'd2;
        write_cmp(100);
        run(600);
        count_high(256, h);
        chk1("R3", "mode2 high count thr100", h, 101);

        // R4: inverted
        out_mode = 2'd3;
        run(300);
        count_high(256, h);
        chk1("R4", "mode3 high count thr100", h, 155);

        // R9: extremes
        write_cmp(0);
        run(600);
        count_high(256, h);
        chk1("R9", "mode3 high count thr0", h, 255);
        out_mode = 2'd2;
        run(300);
        count_high(256, h);
        chk1("R9", "mode2 high count thr0", h, 1);
        write_cmp(255);
        run(600);
        count_high(256, h);
        chk1("R9", "mode2 high count thr255", h, 256);
        out_mode = 2'd3;
        run(300);
        count_high(256, h);
        chk1("R9", "mode3 high count thr255", h, 0);

        // R5: toggle with threshold 0 -> 256 high of 512
        out_mode = 2'd1;
        write_cmp(0);
        run(600);
        count_high(512, h);
        chk1("R5", "toggle high count over 512", h, 256);

        // R6: output off
        out_mode = 2'd0;
        run(2);
        chk1("R6", "wave_oe when off", int'(wave_oe), 0);
        chk1("R6", "wave_out when off", int'(wave_out), 0);

        // R10: double buffer -- write at start of a period with threshold 10
        out_mode = 2'd2;
        write_cmp(10);
        run(600);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        wait_ovf(300);
        h = int'(wave_out);
        ovf_clr = 1'b1; cmp_wr = 1'b1; cmp_wdata = 8'd200;
        for (int i = 0; i < 255; i++) begin
            step();
            ovf_clr = 1'b0; cmp_wr = 1'b0;
            h += int'(wave_out);
        end
        chk1("R10", "old threshold kept for current period", h, 11);
        count_high(256, h);
        chk1("R10", "new threshold in next period", h, 201);

        // R7: divide by 8 gives 2048 clocks between wraps
        clk_sel = 3'd2;
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        wait_ovf(3000);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        gap = 1;
        for (int i = 0; i < 3000 && !ovf_flag; i++) begin
            step();
            gap++;
        end
        chk1("R7", "clocks between wraps at /8", gap, 2048);

        // R12 / R11: interrupt gating and clear
        irq_en = 1'b1; step();
        chk1("R12", "irq with flag and enable", int'(irq), 1);
        irq_en = 1'b0; step();
        chk1("R12", "irq masked", int'(irq), 0);
        clk_sel = 3'd0; run(2);
        ovf_clr = 1'b1; cmp_clr = 1'b1; step();
        ovf_clr = 1'b0; cmp_clr = 1'b0; step();
        chk1("R11", "flags cleared by write-one", int'(ovf_flag) + int'(cmp_flag), 0);

        // R8: restart from stopped at /32: first tick and wrap timing follow the model
        clk_sel = 3'd3; run(200);

        // constrained random mix
        clk_sel = 3'd1;
        for (int i = 0; i < 24000; i++) begin
            int r;
            cmp_wr = 1'b0; ovf_clr = 1'b0; cmp_clr = 1'b0;
            r = int'($urandom % 40);
            if (r == 0) begin
                cmp_wr = 1'b1;
                case ($urandom % 4)
                    0: cmp_wdata = 8'd0;
                    1: cmp_wdata = 8'd255;
                    default: cmp_wdata = 8'($urandom);
                endcase
            end
            if ($urandom % 20 == 0) ovf_clr = 1'b1;
            if ($urandom % 20 == 0) cmp_clr = 1'b1;
            if ($urandom % 100 == 0) irq_en = ~irq_en;
            if ($urandom % 500 == 0) out_mode = 2'($urandom);
            if ($urandom % 900 == 0) begin
                case ($urandom % 6)
                    0: clk_sel = 3'd0;
                    1, 2: clk_sel = 3'd1;
                    3, 4: clk_sel = 3'd2;
                    default: clk_sel = 3'd3;
                endcase
            end
            step();
        end

        done = 1'b1;
        summary();
    end

endmodule